// File: doc/BRIEF.md
# Big-endian host to parallel ATA register bridge

This block sits between a big-endian processor I/O bus and the register interface of a parallel ATA drive. A host request whose address falls inside one aligned I/O window is turned into a complete drive cycle. The block asserts one of the two active-low drive chip selects, drives the low register address, waits a setup time, holds a read or write strobe for a fixed number of clocks, and then returns a one-cycle acknowledge to the host.

The drive reports per register whether it supports a 16-bit transfer. The bridge synchronises that line and samples it before the strobe starts. A 16-bit transfer has its two bytes exchanged between the host lanes and the drive lanes, so sector contents land in the byte order a little-endian PC would store. An 8-bit transfer uses only the drive's low data byte, and that byte is steered to the host lane that matches the parity of the host address.

Top module: `hbus_ata_bridge`

## Requirements
- R1: With the default parameters the window is host addresses 0x01F0 to 0x01FF (`host_addr[15:4]` equal to `WIN_BASE[15:4]`). Bit 3 of `host_addr` picks the drive select: 0 asserts `dev_cs0_n`, 1 asserts `dev_cs1_n`. `dev_addr` carries `host_addr[2:0]` and stays stable while a strobe is active.
- R2: A request outside the window leaves both chip selects high, issues no strobe and raises no `host_ack`.
- R3: The two chip selects are never low together.
- R4: When `dev_iocs16_n` is low before the strobe, the transfer is 16 bits wide with the bytes exchanged. A read returns `host_rdata = {dev_din[7:0], dev_din[15:8]}`. A write drives `dev_dout = {host_wdata[7:0], host_wdata[15:8]}`.
- R5: An 8-bit read (`dev_iocs16_n` high) takes `dev_din[7:0]`. At an even host address that byte goes to `host_rdata[15:8]`, and at an odd address it goes to `host_rdata[7:0]`. The other lane reads zero, and `dev_din[15:8]` is ignored.
- R6: An 8-bit write drives `dev_dout[7:0]` from `host_wdata[15:8]` at an even host address and from `host_wdata[7:0]` at an odd one. `dev_dout[15:8]` is zero.
- R7: The chip select and address are held for `SETUP_CYC` clocks before the strobe. The strobe stays low for `STROBE_CYC` clocks. `host_ack` is high for exactly one clock right after the strobe ends. With the defaults, `host_ack` is seen on the 7th falling clock edge after the request is driven.
- R8: `dev_doe` is high only while `dev_wr_n` is low, and it is never high during a read strobe.
- R9: A request that arrives while a transfer is in progress is ignored.
- R10: During reset both chip selects and both strobes are high, and `host_ack` and `dev_doe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| host_req | input | 1 | one-cycle request pulse |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | host I/O byte address |
| host_wdata | input | 16 | host write data, big-endian lanes |
| host_rdata | output | 16 | read data, valid with host_ack |
| host_ack | output | 1 | one-cycle completion |
| dev_cs0_n | output | 1 | drive chip select, first register set |
| dev_cs1_n | output | 1 | drive chip select, second register set |
| dev_addr | output | 3 | drive register address |
| dev_rd_n | output | 1 | drive read strobe |
| dev_wr_n | output | 1 | drive write strobe |
| dev_dout | output | 16 | data toward the drive |
| dev_doe | output | 1 | output enable for dev_dout |
| dev_din | input | 16 | data from the drive |
| dev_iocs16_n | input | 1 | drive 16-bit capability, active low |

## Verification
The assertions watch the drive-side signals on every clock. They check that the chip selects never overlap, that a strobe only occurs with exactly one select and a stable address, that the output enable only accompanies write strobes, and that every acknowledge is a single pulse that follows a strobe. The bench scenarios cover the rest: lane steering and byte exchange for both transfer widths and both address parities, setup and strobe lengths, the ignored out-of-window and mid-transfer requests, and a data register whose drive denies 16-bit capability. These cases need a drive model and expected byte values.

// File: rtl/hata_pkg.sv
package hata_pkg;
  localparam int DW = 16;
  localparam int BW = DW / 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_ACK    = 2'd3
  } xfer_state_t;
endpackage

// File: rtl/ata_win_decode.sv
module ata_win_decode #(
  parameter int          HOST_AW  = 16,
  parameter int          REG_AW   = 3,
  parameter logic [15:0] WIN_BASE = 16'h01F0
) (
  input  logic [HOST_AW-1:0] addr,
  output logic               hit,
  output logic               sel_hi,
  output logic [REG_AW-1:0]  reg_addr,
  output logic               odd
);
  localparam int WIN_LSB = REG_AW + 1;
  localparam logic [HOST_AW-1:0] BASE = HOST_AW'(WIN_BASE);

  always_comb begin
    hit      = (addr[HOST_AW-1:WIN_LSB] == BASE[HOST_AW-1:WIN_LSB]);
    sel_hi   = addr[REG_AW];
    reg_addr = addr[REG_AW-1:0];
    odd      = addr[0];
  end
endmodule

// File: rtl/ata_lane_swap.sv
module ata_lane_swap
  import hata_pkg::*;
(
  input  logic          wide,
  input  logic          odd,
  input  logic [DW-1:0] h_wdata,
  input  logic [DW-1:0] d_rdata,
  output logic [DW-1:0] d_wdata,
  output logic [DW-1:0] h_rdata
);
  always_comb begin
    if (wide) begin
      d_wdata = {h_wdata[BW-1:0], h_wdata[DW-1:BW]};
      h_rdata = {d_rdata[BW-1:0], d_rdata[DW-1:BW]};
    end else if (odd) begin
      d_wdata = {{BW{1'b0}}, h_wdata[BW-1:0]};
      h_rdata = {{BW{1'b0}}, d_rdata[BW-1:0]};
    end else begin
      d_wdata = {{BW{1'b0}}, h_wdata[DW-1:BW]};
      h_rdata = {d_rdata[BW-1:0], {BW{1'b0}}};
    end
  end
endmodule

// File: rtl/ata_xfer_fsm.sv
module ata_xfer_fsm
  import hata_pkg::*;
#(
  parameter int SETUP_CYC  = 3,
  parameter int STROBE_CYC = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        cap16_n,
  output xfer_state_t state,
  output logic        wide,
  output logic        last_strobe
);
  localparam int CMAX = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  xfer_state_t st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic wide_q, wide_d;
  logic [1:0] sync_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    wide_d = wide_q;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d  = ST_SETUP;
        cnt_d = '0;
      end
      ST_SETUP: if (cnt_q == CW'(SETUP_CYC - 1)) begin
        st_d   = ST_STROBE;
        cnt_d  = '0;
        wide_d = ~sync_q[1];
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      ST_STROBE: if (cnt_q == CW'(STROBE_CYC - 1)) begin
        st_d  = ST_ACK;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      wide_q <= 1'b0;
      sync_q <= 2'b11;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      wide_q <= wide_d;
      sync_q <= {sync_q[0], cap16_n};
    end
  end

  assign state       = st_q;
  assign wide        = wide_q;
  assign last_strobe = (st_q == ST_STROBE) && (cnt_q == CW'(STROBE_CYC - 1));
endmodule

// File: rtl/hbus_ata_bridge.sv
module hbus_ata_bridge
  import hata_pkg::*;
#(
  parameter int          HOST_AW    = 16,
  parameter int          REG_AW     = 3,
  parameter logic [15:0] WIN_BASE   = 16'h01F0,
  parameter int          SETUP_CYC  = 3,
  parameter int          STROBE_CYC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [15:0]        host_wdata,
  output logic [15:0]        host_rdata,
  output logic               host_ack,
  output logic               dev_cs0_n,
  output logic               dev_cs1_n,
  output logic [REG_AW-1:0]  dev_addr,
  output logic               dev_rd_n,
  output logic               dev_wr_n,
  output logic [15:0]        dev_dout,
  output logic               dev_doe,
  input  logic [15:0]        dev_din,
  input  logic               dev_iocs16_n
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              hit, sel_hi_c, odd_c;
  logic [REG_AW-1:0] reg_c;

  ata_win_decode #(.HOST_AW(HOST_AW), .REG_AW(REG_AW), .WIN_BASE(WIN_BASE)) u_dec (
    .addr(host_addr), .hit(hit), .sel_hi(sel_hi_c), .reg_addr(reg_c), .odd(odd_c)
  );

  xfer_state_t st;
  logic        wide, last_strobe, accept;

  assign accept = host_req && hit && (st == ST_IDLE);

  ata_xfer_fsm #(.SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .start(accept), .cap16_n(dev_iocs16_n),
    .state(st), .wide(wide), .last_strobe(last_strobe)
  );

  logic              sel_hi_q, odd_q, we_q;
  logic [REG_AW-1:0] reg_q;
  logic [DW-1:0]     wd_q, rd_q, rd_c, dw_c;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sel_hi_q <= 1'b0;
      odd_q    <= 1'b0;
      we_q     <= 1'b0;
      reg_q    <= '0;
      wd_q     <= '0;
    end else if (accept) begin
      sel_hi_q <= sel_hi_c;
      odd_q    <= odd_c;
      we_q     <= host_we;
      reg_q    <= reg_c;
      wd_q     <= host_wdata;
    end
  end

  ata_lane_swap u_lane (
    .wide(wide), .odd(odd_q), .h_wdata(wd_q), .d_rdata(dev_din),
    .d_wdata(dw_c), .h_rdata(rd_c)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)                rd_q <= '0;
    else if (last_strobe && !we_q) rd_q <= rd_c;
  end

  logic active, strobe;
  assign active = (st != ST_IDLE);
  assign strobe = (st == ST_STROBE);

  assign dev_cs0_n  = !(active && !sel_hi_q);
  assign dev_cs1_n  = !(active &&  sel_hi_q);
  assign dev_addr   = reg_q;
  assign dev_rd_n   = !(strobe && !we_q);
  assign dev_wr_n   = !(strobe &&  we_q);
  assign dev_doe    = strobe && we_q;
  assign dev_dout   = dw_c;
  assign host_rdata = rd_q;
  assign host_ack   = (st == ST_ACK);
endmodule

// File: rtl/hbus_ata_bridge_chk.sv
module hbus_ata_bridge_chk #(
  parameter int REG_AW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_ack,
  input logic              dev_cs0_n,
  input logic              dev_cs1_n,
  input logic [REG_AW-1:0] dev_addr,
  input logic              dev_rd_n,
  input logic              dev_wr_n,
  input logic              dev_doe
);
  p_one_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dev_cs0_n && !dev_cs1_n));

  p_strobe_has_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_rd_n || !dev_wr_n) |-> (dev_cs0_n != dev_cs1_n));

  p_addr_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_rd_n || !dev_wr_n) |=> ((dev_rd_n && dev_wr_n) || $stable(dev_addr)));

  p_doe_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dev_doe |-> (!dev_wr_n && dev_rd_n));

  p_read_no_doe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_rd_n |-> !dev_doe);

  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);

  p_ack_after_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_ack) |-> ($past(!dev_rd_n) || $past(!dev_wr_n)));
endmodule

bind hbus_ata_bridge hbus_ata_bridge_chk #(.REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_ack(host_ack),
  .dev_cs0_n(dev_cs0_n), .dev_cs1_n(dev_cs1_n), .dev_addr(dev_addr),
  .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n), .dev_doe(dev_doe)
);

// File: tb/test_hbus_ata_bridge.sv
module test_hbus_ata_bridge;
  localparam int SETUP = 3;
  localparam int STRB  = 3;
  localparam int LAT   = SETUP + STRB + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [15:0] host_addr = 16'h0, host_wdata = 16'h0;
  logic [15:0] host_rdata;
  logic        host_ack;
  logic        dev_cs0_n, dev_cs1_n, dev_rd_n, dev_wr_n, dev_doe;
  logic [2:0]  dev_addr;
  logic [15:0] dev_dout, dev_din;
  logic        dev_iocs16_n;

  always #2.5 clk = ~clk;

  hbus_ata_bridge #(.SETUP_CYC(SETUP), .STROBE_CYC(STRB)) i_hbus_ata_bridge (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ack(host_ack), .dev_cs0_n(dev_cs0_n), .dev_cs1_n(dev_cs1_n),
    .dev_addr(dev_addr), .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n),
    .dev_dout(dev_dout), .dev_doe(dev_doe), .dev_din(dev_din),
    .dev_iocs16_n(dev_iocs16_n)
  );

  // drive model: 16 byte registers plus a 16-bit data register at select 0, offset 0
  logic [7:0]  mem [16];
  logic [15:0] data16;
  logic        en16 = 1'b1;
  logic        hi_bad = 1'b0;
  logic [3:0]  idx;

  assign idx          = {dev_cs0_n, dev_addr};
  assign dev_iocs16_n = !(!dev_cs0_n && dev_addr == 3'd0 && en16);
  assign dev_din      = !dev_iocs16_n ? data16 : {8'hEE, mem[idx]};

  always @(negedge clk) begin
    if (rst_n && !dev_wr_n) begin
      if (!dev_iocs16_n) data16 <= dev_dout;
      else begin
        mem[idx] <= dev_dout[7:0];
        if (dev_dout[15:8] != 8'h00) hi_bad <= 1'b1;
      end
    end
  end

  int set_cnt, stb_cnt;
  always @(negedge clk) begin
    if (!dev_cs0_n || !dev_cs1_n) begin
      if (!dev_rd_n || !dev_wr_n) stb_cnt++;
      else if (stb_cnt == 0)      set_cnt++;
    end
  end

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic is_wide(logic [15:0] a);
    return (a[3:0] == 4'd0) && en16;
  endfunction

  function automatic logic [15:0] exp_rd(logic [15:0] a);
    logic [7:0] b;
    if (is_wide(a)) return {data16[7:0], data16[15:8]};
    b = mem[a[3:0]];
    return a[0] ? {8'h00, b} : {b, 8'h00};
  endfunction

  task automatic xfer(logic [15:0] a, logic we, logic [15:0] wd,
                      output logic [15:0] rd, output int lat);
    set_cnt = 0; stb_cnt = 0;
    host_addr = a; host_we = we; host_wdata = wd; host_req = 1'b1;
    lat = 0; rd = 16'hxxxx;
    for (int n = 1; n <= 30; n++) begin
      @(negedge clk);
      host_req = 1'b0;
      if (host_ack) begin lat = n; rd = host_rdata; break; end
    end
    @(negedge clk);
  endtask

  task automatic check_write(string req, logic [15:0] a, logic [15:0] wd);
    logic [15:0] rd, exp16; logic [7:0] expb; int lat;
    exp16 = {wd[7:0], wd[15:8]};
    expb  = a[0] ? wd[7:0] : wd[15:8];
    if (is_wide(a)) begin
      xfer(a, 1'b1, wd, rd, lat);
      chk({req, " R4 wide write"}, data16, exp16);
    end else begin
      xfer(a, 1'b1, wd, rd, lat);
      chk({req, " R6 byte write"}, mem[a[3:0]], expb);
    end
    chk({req, " R7 latency"}, lat, LAT);
  endtask

  task automatic check_read(string req, logic [15:0] a);
    logic [15:0] rd, exp; int lat;
    exp = exp_rd(a);
    xfer(a, 1'b0, 16'h0, rd, lat);
    chk(is_wide(a) ? {req, " R4 wide read"} : {req, " R5 byte read"}, rd, exp);
    chk({req, " R7 latency"}, lat, LAT);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] rd, a; int lat, acks; logic quiet;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 16; i++) mem[i] = 8'(i * 17 + 3);
    data16 = 16'h1234;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset cs/strobes/ack/doe",
        {dev_cs0_n, dev_cs1_n, dev_rd_n, dev_wr_n, host_ack, dev_doe}, 6'b111100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4 wide read with exchanged lanes
    data16 = 16'hA1B2;
    check_read("dir", 16'h01F0);
    // R1 select and address routing, R7 setup/strobe lengths
    host_addr = 16'h01FE; host_we = 1'b0; host_req = 1'b1;
    @(negedge clk); host_req = 1'b0;
    chk("R1 cs1 selected", {dev_cs0_n, dev_cs1_n, dev_addr}, {1'b1, 1'b0, 3'd6});
    repeat (LAT) @(negedge clk);
    check_read("dir", 16'h01F3);
    chk("R7 setup cycles", set_cnt, SETUP);
    chk("R7 strobe cycles", stb_cnt, STRB);
    // R5 even and odd byte reads
    check_read("dir even", 16'h01F2);
    check_read("dir odd", 16'h01F9);
    // R4 / R6 writes
    check_write("dir", 16'h01F0, 16'hCAFE);
    check_write("dir even", 16'h01F4, 16'h5A3C);
    check_write("dir odd", 16'h01FB, 16'h5A3C);
    // data register without 16-bit capability: byte on even lane
    en16 = 1'b0; mem[0] = 8'h77;
    check_read("no16", 16'h01F0);
    check_write("no16", 16'h01F0, 16'h9A10);
    en16 = 1'b1;

    // R2 outside the window
    foreach (rd[k]) begin end
    for (int t = 0; t < 4; t++) begin
      a = (t == 0) ? 16'h01E8 : (t == 1) ? 16'h0170 : (t == 2) ? 16'h03F6 : 16'h11F0;
      host_addr = a; host_we = t[0]; host_wdata = 16'hFFFF; host_req = 1'b1;
      quiet = 1'b1;
      for (int n = 0; n < 12; n++) begin
        @(negedge clk); host_req = 1'b0;
        if (!dev_cs0_n || !dev_cs1_n || !dev_rd_n || !dev_wr_n || host_ack) quiet = 1'b0;
      end
      chk("R2 outside window idle", quiet, 1'b1);
    end

    // R9 second request while busy
    mem[4'd12] = 8'h42;
    host_addr = 16'h01F5; host_we = 1'b1; host_wdata = 16'h00D1; host_req = 1'b1;
    @(negedge clk); host_req = 1'b0;
    @(negedge clk);
    host_addr = 16'h01FC; host_we = 1'b1; host_wdata = 16'h0099; host_req = 1'b1;
    @(negedge clk); host_req = 1'b0;
    acks = 0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      if (host_ack) acks++;
    end
    chk("R9 single ack", acks, 1);
    chk("R9 busy request ignored", mem[4'd12], 8'h42);
    chk("R9 first write done", mem[4'd5], 8'hD1);

    // constrained random mix
    for (int i = 0; i < 60; i++) begin
      a = {12'h01F, 4'($urandom_range(0, 15))};
      if ($urandom_range(0, 1) == 1) check_write("rnd", a, 16'($urandom));
      else begin
        if (a[3:0] == 4'd0) data16 = 16'($urandom);
        check_read("rnd", a);
      end
    end
    chk("R6 upper lane zero on byte writes", hi_bad, 1'b0);
    finish_run();
  end
endmodule